// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers interrupt requests from two sets of 32 sources and raises a single interrupt line towards a CPU. The primary set feeds the CPU directly. The secondary set holds peripheral sources, and its pending bits are collapsed into three summary bits that take fixed places in the primary set. Both sets have a mask register and a status view. Each source is fixed at build time as either level-sensitive or edge-latched. Level bits follow a synchronized copy of their input. Edge bits hold a latch that a rising edge sets and that software clears by writing zero to that bit.

Software uses a small register port. The port has a write strobe and a combinational read mux, and it reaches both mask registers, both status views and a software-trigger register. Besides the registered interrupt line, an optional encoder reports the lowest pending source. When that source is a summary bit, the encoder reports the pending secondary source behind it instead.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset both mask registers read 0, both status views read 0, `irq_o` is 0 and `src_valid_o` is 0.
- R2: A level-sensitive primary input held high shows as 1 in the primary status view (address 1) two clocks later. It reads 0 again once the input has been low for two clocks.
- R3: A source raises `irq_o` only when its mask bit is 1. Primary mask is address 0 and secondary mask is address 2. With the mask bit 0 the status bit still reads 1, but `irq_o` stays 0.
- R4: An edge-latched bit sets on a rising input edge and stays set after the input falls. A write to its status address with that bit 0 clears it. A write with that bit 1 leaves it set.
- R5: If an edge latch is set and cleared by a write in the same cycle, the latch ends up set.
- R6: Secondary bits 16, 22 and 28 are edge-latched and are cleared through address 3. All other secondary bits are level-sensitive.
- R7: Secondary bits 16-31 fold into primary bit 4, bits 8-15 into primary bit 5, and bits 0-7 into primary bit 6. A summary bit reads 1 only when secondary status AND secondary mask has a set bit in its group.
- R8: Writing 1 to bits 28, 29 or 30 at address 4 sets those primary edge latches. Other bits of that write have no effect. The latches clear like any other edge bit.
- R9: `irq_o` is the OR of primary status AND primary mask, registered. It changes on the clock edge after the edge that changed the mask or status.
- R10: `src_idx_o` gives the lowest pending primary index, and `src_valid_o` is high when any source is pending. When the lowest pending bit is a summary bit, `src_idx_o` is 32 plus the lowest pending secondary index inside that bit's group.
- R11: Primary bits 16-19, 22-24 and 28-31 are edge-latched. Bits 0-3, 7-15, 20-21 and 25-27 are level-sensitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| prim_src_i | input | 32 | Primary source inputs (bits 4-6 unused) |
| sec_src_i | input | 32 | Secondary source inputs |
| reg_addr_i | input | 3 | Register select: 0 pmask, 1 pstat, 2 smask, 3 sstat, 4 soft |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Registered CPU interrupt |
| src_idx_o | output | 6 | Lowest pending source index (32+ for secondary) |
| src_valid_o | output | 1 | Some source is pending |

## Verification
A level input is held and then released, so that it can be told apart from an edge input that is only pulsed and must stay latched. Clear writes carry both 0 and 1 in the latched bit, which separates write-zero-clears from write-one-clears. One clear write is timed exactly onto the cycle in which the latch sets, to show which of the two wins. Secondary sources are driven in each group with the secondary mask open and closed. Two groups are made pending at the same time, so the encoder must pick the secondary index behind the lowest summary bit rather than the lowest secondary bit overall.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
   localparam int REG_AW     = 3;
   localparam int NUM_GROUPS = 3;

   typedef enum logic [REG_AW-1:0] {
      SEL_PMASK = 3'd0,
      SEL_PSTAT = 3'd1,
      SEL_SMASK = 3'd2,
      SEL_SSTAT = 3'd3,
      SEL_SOFT  = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int           W           = 32,
   parameter int           SYNC_STAGES = 2,
   parameter logic [W-1:0] EDGE_MAP    = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] soft_set_i,
   input  logic         clr_wr_i,
   input  logic [W-1:0] clr_data_i,
   output logic [W-1:0] status_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_src_bank: SYNC_STAGES must be at least 2");
   end

   logic [W-1:0] sync_q [SYNC_STAGES];
   logic [W-1:0] prev_q;
   logic [W-1:0] latch_q;
   logic [W-1:0] set_vec;
   logic [W-1:0] clr_vec;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
         prev_q <= '0;
      end else begin
         sync_q[0] <= src_i;
         for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
         prev_q <= sync_q[LAST];
      end
   end

   assign set_vec = ((sync_q[LAST] & ~prev_q) | soft_set_i) & EDGE_MAP;
   assign clr_vec = clr_wr_i ? ~clr_data_i : '0;

   // set term applied after clear: a new edge beats a same-cycle clear
   always_ff @(posedge clk_i) begin
      if (!rst_ni) latch_q <= '0;
      else         latch_q <= ((latch_q & ~clr_vec) | set_vec) & EDGE_MAP;
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (EDGE_MAP[b]) begin : g_edge
         assign status_o[b] = latch_q[b];
      end else begin : g_level
         assign status_o[b] = sync_q[LAST][b];
      end
   end

   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_vec != '0) |=> ((latch_q & $past(set_vec)) == $past(set_vec))); // R5

   AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_wr_i |=> ((latch_q & $past(~clr_data_i & ~set_vec)) == '0)); // R4

   AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_wr_i |=> (($past(latch_q) & ~latch_q) == '0)); // R4
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
   parameter int W  = 32,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec_i,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   if (W < 1) begin : g_bad_w
      $error("irq_first_set: W must be positive");
   end

   always_comb begin
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end

   assign any_o = |vec_i;
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
   import casc_irq_pkg::*;
#(
   parameter int           W           = 32,
   parameter int           SYNC_STAGES = 2,
   parameter logic [W-1:0] P_EDGE      = 32'hF1CF_0000,
   parameter logic [W-1:0] S_EDGE      = 32'h1041_0000,
   parameter logic [W-1:0] P_SOFT      = 32'h7000_0000,
   parameter int           SUM_HI      = 4,
   parameter int           SUM_MID     = 5,
   parameter int           SUM_LO      = 6,
   parameter logic [W-1:0] GRP_HI      = 32'hFFFF_0000,
   parameter logic [W-1:0] GRP_MID     = 32'h0000_FF00,
   parameter logic [W-1:0] GRP_LO      = 32'h0000_00FF,
   parameter bit           HAS_ENCODER = 1'b1,
   localparam int          IW          = $clog2(2 * W),
   localparam int          PW          = $clog2(W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [W-1:0]      prim_src_i,
   input  logic [W-1:0]      sec_src_i,
   input  logic [REG_AW-1:0] reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [W-1:0]      reg_wdata_i,
   output logic [W-1:0]      reg_rdata_o,
   output logic              irq_o,
   output logic [IW-1:0]     src_idx_o,
   output logic              src_valid_o
);
   localparam int           SUM_POS [NUM_GROUPS] = '{SUM_HI, SUM_MID, SUM_LO};
   localparam logic [W-1:0] GRP     [NUM_GROUPS] = '{GRP_HI, GRP_MID, GRP_LO};
   localparam logic [W-1:0] SUM_MASK = (W'(1) << SUM_HI) | (W'(1) << SUM_MID)
                                     | (W'(1) << SUM_LO);

   if (SUM_HI >= W || SUM_MID >= W || SUM_LO >= W) begin : g_bad_pos
      $error("casc_irq_ctrl: summary position out of range");
   end
   if ((GRP_HI & GRP_MID) != '0 || (GRP_HI & GRP_LO) != '0
       || (GRP_MID & GRP_LO) != '0) begin : g_bad_grp
      $error("casc_irq_ctrl: secondary groups overlap");
   end
   if ((P_EDGE & SUM_MASK) != '0) begin : g_bad_sum_edge
      $error("casc_irq_ctrl: summary bits cannot be edge-latched");
   end
   if ((P_SOFT & ~P_EDGE) != '0) begin : g_bad_soft
      $error("casc_irq_ctrl: software bits must be edge-latched");
   end

   logic [W-1:0] p_mask_q, s_mask_q;
   logic [W-1:0] p_bank_stat, s_stat, p_stat;
   logic [W-1:0] p_pend, s_pend, sum_vec;
   logic [W-1:0] soft_set;
   logic         p_clr_wr, s_clr_wr;
   logic         irq_q;

   assign p_clr_wr = reg_wr_i && (reg_sel_e'(reg_addr_i) == SEL_PSTAT);
   assign s_clr_wr = reg_wr_i && (reg_sel_e'(reg_addr_i) == SEL_SSTAT);
   assign soft_set = (reg_wr_i && (reg_sel_e'(reg_addr_i) == SEL_SOFT))
                     ? (reg_wdata_i & P_SOFT) : '0;

   irq_src_bank #(.W(W), .SYNC_STAGES(SYNC_STAGES), .EDGE_MAP(P_EDGE)) u_prim (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (prim_src_i),
      .soft_set_i (soft_set),
      .clr_wr_i   (p_clr_wr),
      .clr_data_i (reg_wdata_i),
      .status_o   (p_bank_stat)
   );

   irq_src_bank #(.W(W), .SYNC_STAGES(SYNC_STAGES), .EDGE_MAP(S_EDGE)) u_sec (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (sec_src_i),
      .soft_set_i ('0),
      .clr_wr_i   (s_clr_wr),
      .clr_data_i (reg_wdata_i),
      .status_o   (s_stat)
   );

   assign s_pend = s_stat & s_mask_q;

   always_comb begin
      sum_vec = '0;
      for (int k = 0; k < NUM_GROUPS; k++) begin
         sum_vec[SUM_POS[k]] = |(s_pend & GRP[k]);
      end
   end

   assign p_stat = (p_bank_stat & ~SUM_MASK) | sum_vec;
   assign p_pend = p_stat & p_mask_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         p_mask_q <= '0;
         s_mask_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         if (reg_wr_i && reg_sel_e'(reg_addr_i) == SEL_PMASK) p_mask_q <= reg_wdata_i;
         if (reg_wr_i && reg_sel_e'(reg_addr_i) == SEL_SMASK) s_mask_q <= reg_wdata_i;
         irq_q <= |p_pend;
      end
   end

   assign irq_o = irq_q;

   always_comb begin
      case (reg_sel_e'(reg_addr_i))
         SEL_PMASK: reg_rdata_o = p_mask_q;
         SEL_PSTAT: reg_rdata_o = p_stat;
         SEL_SMASK: reg_rdata_o = s_mask_q;
         SEL_SSTAT: reg_rdata_o = s_stat;
         default:   reg_rdata_o = '0;
      endcase
   end

   if (HAS_ENCODER) begin : g_enc
      logic [PW-1:0] p_idx, s_idx;
      logic          p_any, s_any;
      logic [W-1:0]  grp_sel;

      irq_first_set #(.W(W), .IW(PW)) u_pfirst (
         .vec_i (p_pend),
         .idx_o (p_idx),
         .any_o (p_any)
      );

      always_comb begin
         grp_sel = '0;
         for (int k = 0; k < NUM_GROUPS; k++) begin
            if (int'(p_idx) == SUM_POS[k]) grp_sel = GRP[k];
         end
      end

      irq_first_set #(.W(W), .IW(PW)) u_sfirst (
         .vec_i (s_pend & grp_sel),
         .idx_o (s_idx),
         .any_o (s_any)
      );

      assign src_valid_o = p_any;
      assign src_idx_o   = (SUM_MASK[p_idx] && s_any) ? (IW'(W) + IW'(s_idx))
                                                      : IW'(p_idx);

      AST_VALID_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         src_valid_o == (|(p_stat & p_mask_q))); // R10

      AST_IDX_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (src_valid_o && src_idx_o < IW'(W)) |-> p_pend[src_idx_o[PW-1:0]]); // R10
   end else begin : g_no_enc
      assign src_valid_o = 1'b0;
      assign src_idx_o   = '0;
   end

   AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|p_pend) |=> irq_o); // R9

   AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|p_pend) |=> !irq_o); // R9

   AST_MASK_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (p_mask_q == '0) |=> !irq_o); // R3

   AST_SUM_NEEDS_SMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_mask_q == '0) |-> ((reg_sel_e'(reg_addr_i) != SEL_PSTAT)
                            || ((reg_rdata_o & SUM_MASK) == '0))); // R7
endmodule

// File: tb/casc_irq_ctrl_bench.sv
`timescale 1ns/1ps
module casc_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] prim_src = '0;
   logic [31:0] sec_src = '0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic [5:0]  src_idx;
   logic        src_valid;

   always #2.5 clk = ~clk;

   casc_irq_ctrl u_casc_irq_ctrl (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .prim_src_i  (prim_src),
      .sec_src_i   (sec_src),
      .reg_addr_i  (reg_addr),
      .reg_wr_i    (reg_wr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irq_o       (irq),
      .src_idx_o   (src_idx),
      .src_valid_o (src_valid)
   );

   typedef struct {
      string       tag;
      logic [31:0] act;
      logic [31:0] exp;
   } item_t;

   item_t sb_q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   // driver side: record observed value with its expectation
   task automatic expect_val(string tag, logic [31:0] act, logic [31:0] exp);
      item_t it;
      it.tag = tag;
      it.act = act;
      it.exp = exp;
      sb_q.push_back(it);
   endtask

   // monitor side: pop and compare
   initial begin
      forever begin
         item_t it;
         wait (sb_q.size() != 0);
         it = sb_q.pop_front();
         n_cmp++;
         if (it.act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", it.tag, it.act, it.exp);
         end
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      prim_src = '0;
      sec_src = '0;
      reg_wr = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      reg_addr = a;
      reg_wdata = d;
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   initial begin
      logic [31:0] v;
      do_reset();

      // R1 reset state
      rd(3'd0, v); expect_val("R1 pmask", v, 32'h0);
      rd(3'd2, v); expect_val("R1 smask", v, 32'h0);
      rd(3'd1, v); expect_val("R1 pstat", v, 32'h0);
      rd(3'd3, v); expect_val("R1 sstat", v, 32'h0);
      expect_val("R1 irq", {31'b0, irq}, 32'h0);
      expect_val("R1 valid", {31'b0, src_valid}, 32'h0);

      // R2 / R3 / R9 / R10 level primary source
      prim_src[9] = 1'b1;
      cyc(4);
      rd(3'd1, v); expect_val("R2 level status", v, 32'h0000_0200);
      expect_val("R3 masked irq low", {31'b0, irq}, 32'h0);
      wr(3'd0, 32'h0000_0200);
      expect_val("R9 irq not yet", {31'b0, irq}, 32'h0);
      cyc(1);
      expect_val("R9 irq one cycle later", {31'b0, irq}, 32'h1);
      expect_val("R10 idx level", {26'b0, src_idx}, 32'd9);
      expect_val("R10 valid", {31'b0, src_valid}, 32'h1);
      prim_src[9] = 1'b0;
      cyc(4);
      rd(3'd1, v); expect_val("R2 level released", v, 32'h0);
      expect_val("R2 irq released", {31'b0, irq}, 32'h0);
      expect_val("R10 valid low", {31'b0, src_valid}, 32'h0);

      // R4 / R11 primary edge latch
      do_reset();
      prim_src[17] = 1'b1; cyc(3); prim_src[17] = 1'b0;
      prim_src[20] = 1'b1; cyc(3); prim_src[20] = 1'b0;
      cyc(4);
      rd(3'd1, v); expect_val("R11 edge17 held, level20 gone", v, 32'h0002_0000);
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd1, v); expect_val("R4 write one keeps", v, 32'h0002_0000);
      wr(3'd1, ~32'h0002_0000);
      rd(3'd1, v); expect_val("R4 write zero clears", v, 32'h0);

      // R5 set and clear collide on bit 22
      do_reset();
      prim_src[22] = 1'b1;
      cyc(2);
      wr(3'd1, ~32'h0040_0000);
      rd(3'd1, v); expect_val("R5 set beats clear", v, 32'h0040_0000);
      wr(3'd1, ~32'h0040_0000);
      rd(3'd1, v); expect_val("R5 later clear works", v, 32'h0);

      // R8 software bits
      do_reset();
      wr(3'd4, 32'h7000_0001);
      rd(3'd1, v); expect_val("R8 soft set", v, 32'h7000_0000);
      wr(3'd1, 32'h0);
      rd(3'd1, v); expect_val("R8 soft clear", v, 32'h0);

      // R6 / R7 secondary level and summary
      do_reset();
      sec_src[3] = 1'b1;
      cyc(4);
      rd(3'd3, v); expect_val("R6 sec level", v, 32'h0000_0008);
      rd(3'd1, v); expect_val("R7 smask closed", v, 32'h0);
      wr(3'd2, 32'h0000_0008);
      rd(3'd1, v); expect_val("R7 low group to bit6", v, 32'h0000_0040);
      sec_src[3] = 1'b0;
      sec_src[12] = 1'b1;
      wr(3'd2, 32'hFFFF_FFFF);
      cyc(4);
      rd(3'd1, v); expect_val("R7 mid group to bit5", v, 32'h0000_0020);
      sec_src[12] = 1'b0;

      // R6 secondary edge bit 16
      do_reset();
      sec_src[16] = 1'b1; sec_src[17] = 1'b1; cyc(3);
      sec_src[16] = 1'b0; sec_src[17] = 1'b0; cyc(4);
      rd(3'd3, v); expect_val("R6 sec edge held", v, 32'h0001_0000);
      wr(3'd2, 32'h0001_0000);
      rd(3'd1, v); expect_val("R7 high group to bit4", v, 32'h0000_0010);
      wr(3'd0, 32'h0000_0010);
      cyc(2);
      expect_val("R7 summary irq", {31'b0, irq}, 32'h1);
      expect_val("R10 idx sec16", {26'b0, src_idx}, 32'd48);
      wr(3'd3, 32'h0);
      rd(3'd3, v); expect_val("R6 sec clear", v, 32'h0);
      cyc(2);
      expect_val("R6 irq after clear", {31'b0, irq}, 32'h0);

      // R10 two groups pending, lowest summary picks its own group
      do_reset();
      prim_src[2] = 1'b1;
      sec_src[0] = 1'b1;
      sec_src[20] = 1'b1;
      cyc(4);
      wr(3'd2, 32'h0010_0001);
      wr(3'd0, 32'h0000_0070);
      rd(3'd1, v); expect_val("R7 two summaries", v, 32'h0000_0054);
      expect_val("R10 idx sec20", {26'b0, src_idx}, 32'd52);
      wr(3'd0, 32'h0000_0074);
      expect_val("R10 idx primary2", {26'b0, src_idx}, 32'd2);

      cyc(2);
      wait (sb_q.size() == 0);
      #1;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule